// File: doc/BRIEF.md
# Integer Execute Stage

This block is the integer execute step of a simple 32-bit load-store processor pipeline. Each cycle it may accept one operation: an opcode, two register operands and a 16-bit immediate. From these it forms a full-width result. The operations are addition and subtraction (signed-trapping and non-trapping forms), bitwise logic, load-upper-immediate, variable shifts, equality and inequality tests, and the widening of raw byte or halfword load data. Every operation writes the whole destination word.

Results are captured on one rising clock edge, so a valid request shows up as a valid result one cycle later. Alongside the result the block reports signed overflow. When overflow is flagged, the result is still shown, but the destination write enable stays low so the register file is left unchanged.

The way an immediate is widened depends on the operation class. Arithmetic forms, including the non-trapping add-immediate, replicate the sign bit. Logical forms fill the upper bits with zeros.

Top module: `rx_int_exec`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the next cycle. Without a request, `out_valid` is low and `result` and `ovf` keep their last values.
- R2: Opcode 0 (add) and opcode 1 (add, no trap) give a+b. Opcode 2 (sub) and opcode 3 (sub, no trap) give a-b. All four wrap modulo 2^32.
- R3: `ovf` is raised only for opcodes 0, 2 and 8, and only on signed overflow: both addends have the same sign and the sum has the other sign. Subtraction adds the inverted second operand.
- R4: When `ovf` is set, `result` still carries the wrapped value and `out_wr_en` is low. Otherwise `out_wr_en` equals `out_valid`.
- R5: Opcodes 4, 5, 6 and 7 give a AND b, a OR b, a XOR b and NOT(a OR b).
- R6: Opcode 8 (add immediate, trapping) and opcode 9 (add immediate, no trap) add `opnd_a` to the sign-extended immediate.
- R7: Opcodes 10, 11 and 12 give AND, OR and XOR of `opnd_a` with the zero-extended immediate.
- R8: Opcode 13 places `imm` in result bits 31:16 and clears bits 15:0.
- R9: Opcode 14 shifts `opnd_a` left logically, opcode 15 shifts it right logically, and opcode 16 shifts it right arithmetically. The amount is `opnd_b[4:0]`, and the upper bits of `opnd_b` are ignored.
- R10: Opcode 17 gives 1 when a equals b and 0 otherwise. Opcode 18 gives 1 when they differ and 0 otherwise.
- R11: Opcodes 19 and 20 widen `opnd_a[7:0]` with sign and zero fill respectively. Opcodes 21 and 22 do the same for `opnd_a[15:0]`.
- R12: Opcodes 23 to 31 give a result of 0 with `ovf` low.
- R13: While reset is asserted, `out_valid`, `result`, `ovf` and `out_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| op | input | 5 | Operation code |
| opnd_a | input | 32 | First operand, shift source, raw load data |
| opnd_b | input | 32 | Second operand, shift amount in bits 4:0 |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Full-width result |
| ovf | output | 1 | Signed overflow on the captured operation |
| out_wr_en | output | 1 | Destination write permitted |

## Verification
Each arithmetic opcode is driven both with operand pairs that stay in range and with pairs that cross the signed boundary in each direction. This separates the trapping forms from the non-trapping forms and exposes a wrongly inverted subtrahend. Immediates with bit 15 set are applied to both arithmetic and logical forms, which shows whether each class picks the right fill. Shifts use amounts of 0, 1, 4 and 31, a negative source, and an amount with high garbage bits, so that left and right shifts, logical and arithmetic fills, and masking of the amount are all distinguished. Byte and halfword loads use data whose top bit is set and data whose top bit is clear.

// File: rtl/rx_exec_pkg.sv
package rx_exec_pkg;

   localparam int OPW = 5;

   typedef enum logic [OPW-1:0] {
      OP_ADD   = 5'd0,
      OP_ADDU  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBU  = 5'd3,
      OP_AND   = 5'd4,
      OP_OR    = 5'd5,
      OP_XOR   = 5'd6,
      OP_NOR   = 5'd7,
      OP_ADDI  = 5'd8,
      OP_ADDIU = 5'd9,
      OP_ANDI  = 5'd10,
      OP_ORI   = 5'd11,
      OP_XORI  = 5'd12,
      OP_LUI   = 5'd13,
      OP_SLL   = 5'd14,
      OP_SRL   = 5'd15,
      OP_SRA   = 5'd16,
      OP_SEQ   = 5'd17,
      OP_SNE   = 5'd18,
      OP_LB    = 5'd19,
      OP_LBU   = 5'd20,
      OP_LH    = 5'd21,
      OP_LHU   = 5'd22
   } exec_op_e;

   localparam int SHIFT_BARREL = 0;
   localparam int SHIFT_OPER   = 1;

endpackage

// File: rtl/rx_imm_ext.sv
module rx_imm_ext #(
   parameter int IMMW = 16,
   parameter int XLEN = 32
) (
   input  logic [IMMW-1:0] imm,
   input  logic            zero_fill,
   output logic [XLEN-1:0] imm_wide
);
   localparam int PADW = XLEN - IMMW;

   logic fill_bit;

   always_comb begin
      fill_bit = zero_fill ? 1'b0 : imm[IMMW-1];
      imm_wide = {{PADW{fill_bit}}, imm};
   end
endmodule

// File: rtl/rx_addsub.sv
module rx_addsub #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic            subtract,
   output logic [XLEN-1:0] sum,
   output logic            sgn_ovf
);
   localparam int MSB = XLEN - 1;

   logic [XLEN-1:0] b_eff;

   always_comb begin
      b_eff   = subtract ? ~b : b;
      sum     = a + b_eff + {{(XLEN-1){1'b0}}, subtract};
      sgn_ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
   parameter int XLEN  = 32,
   parameter int SHW   = 5,
   parameter int STYLE = 0
) (
   input  logic [XLEN-1:0] din,
   input  logic [SHW-1:0]  amt,
   input  logic            go_left,
   input  logic            arith,
   output logic [XLEN-1:0] dout
);
   generate
      if (STYLE == 0) begin : g_barrel
         logic [XLEN-1:0] src;
         logic            fill;
         logic [XLEN-1:0] stg [SHW+1];

         always_comb begin
            for (int i = 0; i < XLEN; i++) begin
               src[i] = go_left ? din[XLEN-1-i] : din[i];
            end
            fill = arith & ~go_left & din[XLEN-1];
         end

         assign stg[0] = src;

         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            assign stg[s+1] = amt[s] ? {{DIST{fill}}, stg[s][XLEN-1:DIST]} : stg[s];
         end

         always_comb begin
            for (int i = 0; i < XLEN; i++) begin
               dout[i] = go_left ? stg[SHW][XLEN-1-i] : stg[SHW][i];
            end
         end
      end else begin : g_oper
         always_comb begin
            if (go_left) begin
               dout = din << amt;
            end else if (arith) begin
               dout = $unsigned($signed(din) >>> amt);
            end else begin
               dout = din >> amt;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rx_load_ext.sv
module rx_load_ext #(
   parameter int HALFW = 16,
   parameter int XLEN  = 32
) (
   input  logic [HALFW-1:0] raw,
   input  logic             half_sel,
   input  logic             sign_sel,
   output logic [XLEN-1:0]  wide
);
   localparam int BYTEW = HALFW / 2;

   logic top_bit;

   always_comb begin
      if (half_sel) begin
         top_bit = sign_sel & raw[HALFW-1];
         wide    = {{(XLEN-HALFW){top_bit}}, raw};
      end else begin
         top_bit = sign_sel & raw[BYTEW-1];
         wide    = {{(XLEN-BYTEW){top_bit}}, raw[BYTEW-1:0]};
      end
   end
endmodule

// File: rtl/rx_int_exec.sv
module rx_int_exec
   import rx_exec_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int IMMW        = 16,
   parameter int SHIFT_STYLE = SHIFT_BARREL
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [4:0]      op,
   input  logic [XLEN-1:0] opnd_a,
   input  logic [XLEN-1:0] opnd_b,
   input  logic [IMMW-1:0] imm,
   output logic            out_valid,
   output logic [XLEN-1:0] result,
   output logic            ovf,
   output logic            out_wr_en
);
   localparam int SHW = $clog2(XLEN);

   generate
      if (XLEN != 2 * IMMW) begin : g_bad_width
         $error("rx_int_exec: XLEN must be twice IMMW");
      end
      if ((XLEN & (XLEN - 1)) != 0 || XLEN < 16) begin : g_bad_pow2
         $error("rx_int_exec: XLEN must be a power of two of at least 16");
      end
      if (SHIFT_STYLE != SHIFT_BARREL && SHIFT_STYLE != SHIFT_OPER) begin : g_bad_style
         $error("rx_int_exec: unknown SHIFT_STYLE");
      end
   endgenerate

   exec_op_e        op_e;
   logic            use_imm;
   logic            imm_zero;
   logic            do_sub;
   logic            traps;
   logic [XLEN-1:0] imm_wide;
   logic [XLEN-1:0] b_sel;
   logic [XLEN-1:0] sum;
   logic            sum_ovf;
   logic [XLEN-1:0] shifted;
   logic [XLEN-1:0] loaded;
   logic            same;
   logic [XLEN-1:0] nxt_res;
   logic            nxt_ovf;

   always_comb begin
      op_e     = exec_op_e'(op);
      use_imm  = (op_e == OP_ADDI) || (op_e == OP_ADDIU) || (op_e == OP_ANDI) ||
                 (op_e == OP_ORI)  || (op_e == OP_XORI);
      imm_zero = (op_e == OP_ANDI) || (op_e == OP_ORI) || (op_e == OP_XORI);
      do_sub   = (op_e == OP_SUB) || (op_e == OP_SUBU);
      traps    = (op_e == OP_ADD) || (op_e == OP_SUB) || (op_e == OP_ADDI);
      b_sel    = use_imm ? imm_wide : opnd_b;
      same     = (opnd_a == opnd_b);
   end

   rx_imm_ext #(.IMMW(IMMW), .XLEN(XLEN)) u_imm (
      .imm       (imm),
      .zero_fill (imm_zero),
      .imm_wide  (imm_wide)
   );

   rx_addsub #(.XLEN(XLEN)) u_add (
      .a        (opnd_a),
      .b        (b_sel),
      .subtract (do_sub),
      .sum      (sum),
      .sgn_ovf  (sum_ovf)
   );

   rx_shifter #(.XLEN(XLEN), .SHW(SHW), .STYLE(SHIFT_STYLE)) u_shf (
      .din     (opnd_a),
      .amt     (opnd_b[SHW-1:0]),
      .go_left (op_e == OP_SLL),
      .arith   (op_e == OP_SRA),
      .dout    (shifted)
   );

   rx_load_ext #(.HALFW(IMMW), .XLEN(XLEN)) u_ld (
      .raw      (opnd_a[IMMW-1:0]),
      .half_sel ((op_e == OP_LH) || (op_e == OP_LHU)),
      .sign_sel ((op_e == OP_LB) || (op_e == OP_LH)),
      .wide     (loaded)
   );

   always_comb begin
      nxt_ovf = 1'b0;
      unique case (op_e)
         OP_ADD, OP_ADDU, OP_SUB, OP_SUBU, OP_ADDI, OP_ADDIU: begin
            nxt_res = sum;
            nxt_ovf = traps & sum_ovf;
         end
         OP_AND, OP_ANDI:            nxt_res = opnd_a & b_sel;
         OP_OR, OP_ORI:              nxt_res = opnd_a | b_sel;
         OP_XOR, OP_XORI:            nxt_res = opnd_a ^ b_sel;
         OP_NOR:                     nxt_res = ~(opnd_a | b_sel);
         OP_LUI:                     nxt_res = {imm, {IMMW{1'b0}}};
         OP_SLL, OP_SRL, OP_SRA:     nxt_res = shifted;
         OP_SEQ:                     nxt_res = {{(XLEN-1){1'b0}}, same};
         OP_SNE:                     nxt_res = {{(XLEN-1){1'b0}}, ~same};
         OP_LB, OP_LBU, OP_LH, OP_LHU: nxt_res = loaded;
         default:                    nxt_res = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         ovf       <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= nxt_res;
            ovf    <= nxt_ovf;
         end
      end
   end

   assign out_wr_en = out_valid & ~ovf;

endmodule

// File: rtl/rx_int_exec_chk.sv
module rx_int_exec_chk
   import rx_exec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [4:0]      op,
   input logic            out_valid,
   input logic [XLEN-1:0] result,
   input logic            ovf,
   input logic            out_wr_en
);
   logic signed_form;
   logic safe_form;
   logic cmp_form;
   logic unused_form;

   always_comb begin
      signed_form = (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI);
      safe_form   = (op == OP_ADDU) || (op == OP_SUBU) || (op == OP_ADDIU) ||
                    (op == OP_AND) || (op == OP_OR) || (op == OP_SLL);
      cmp_form    = (op == OP_SEQ) || (op == OP_SNE);
      unused_form = (op > OP_LHU);
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                                // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(ovf)));         // R1
   AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !signed_form) |=> !ovf);                                   // R3
   AST_SAFE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && safe_form) |=> out_wr_en);                                 // R4
   AST_LUI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_LUI) |=> (result[XLEN/2-1:0] == '0));             // R8
   AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmp_form) |=> (result[XLEN-1:1] == '0));                   // R10
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && unused_form) |=> (result == '0 && !ovf));                  // R12
endmodule

bind rx_int_exec rx_int_exec_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .out_valid (out_valid),
   .result    (result),
   .ovf       (ovf),
   .out_wr_en (out_wr_en)
);

// File: tb/tb_rx_int_exec.sv
module tb_rx_int_exec;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  op = '0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [15:0] imm = '0;
   logic        out_valid;
   logic [31:0] result;
   logic        ovf;
   logic        out_wr_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_int_exec dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op        (op),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .imm       (imm),
      .out_valid (out_valid),
      .result    (result),
      .ovf       (ovf),
      .out_wr_en (out_wr_en)
   );

   task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual={v,res,ovf,we}=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input string tag, input logic [4:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] i,
                         input logic [31:0] exp_res, input logic exp_ovf);
      @(negedge clk);
      in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; imm = i;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, {out_valid, result, ovf, out_wr_en}, {1'b1, exp_res, exp_ovf, ~exp_ovf});
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R13 reset state", {out_valid, result, ovf, out_wr_en}, 35'd0);
   endtask

   task automatic t_addsub();
      run_op("R2 add",              5'd0, 32'd5,          32'd7, 16'h0, 32'd12, 1'b0);
      run_op("R3 R4 add overflow",  5'd0, 32'h7FFF_FFFF,  32'd1, 16'h0, 32'h8000_0000, 1'b1);
      run_op("R3 addu no trap",     5'd1, 32'h7FFF_FFFF,  32'd1, 16'h0, 32'h8000_0000, 1'b0);
      run_op("R3 R4 sub overflow",  5'd2, 32'h8000_0000,  32'd1, 16'h0, 32'h7FFF_FFFF, 1'b1);
      run_op("R2 sub",              5'd2, 32'd10,         32'd3, 16'h0, 32'd7, 1'b0);
      run_op("R2 R3 subu wrap",     5'd3, 32'd3,          32'd5, 16'h0, 32'hFFFF_FFFE, 1'b0);
      run_op("R3 add neg overflow", 5'd0, 32'h8000_0000,  32'h8000_0000, 16'h0, 32'h0, 1'b1);
   endtask

   task automatic t_logic();
      run_op("R5 and", 5'd4, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0, 32'h00F0_1234, 1'b0);
      run_op("R5 or",  5'd5, 32'hF000_0000, 32'h0000_000F, 16'h0, 32'hF000_000F, 1'b0);
      run_op("R5 xor", 5'd6, 32'hFF00_FF00, 32'h0FF0_0FF0, 16'h0, 32'hF0F0_F0F0, 1'b0);
      run_op("R5 nor", 5'd7, 32'h0000_0000, 32'h0000_00FF, 16'h0, 32'hFFFF_FF00, 1'b0);
   endtask

   task automatic t_imm();
      run_op("R6 addi neg imm",     5'd8,  32'd10,         32'hDEAD_BEEF, 16'hFFFF, 32'd9, 1'b0);
      run_op("R6 addiu sign fill",  5'd9,  32'd0,          32'h0,         16'h8000, 32'hFFFF_8000, 1'b0);
      run_op("R3 R6 addi overflow", 5'd8,  32'h7FFF_FFFF,  32'h0,         16'h0001, 32'h8000_0000, 1'b1);
      run_op("R3 R6 addiu no trap", 5'd9,  32'h7FFF_FFFF,  32'h0,         16'h0001, 32'h8000_0000, 1'b0);
      run_op("R7 andi zero fill",   5'd10, 32'hFFFF_FFFF,  32'h0,         16'h8001, 32'h0000_8001, 1'b0);
      run_op("R7 ori zero fill",    5'd11, 32'h0,          32'hFFFF_FFFF, 16'hFFFF, 32'h0000_FFFF, 1'b0);
      run_op("R7 xori zero fill",   5'd12, 32'hFFFF_0000,  32'h0,         16'hFFFF, 32'hFFFF_FFFF, 1'b0);
   endtask

   task automatic t_lui();
      run_op("R8 lui", 5'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 32'hABCD_0000, 1'b0);
   endtask

   task automatic t_shift();
      run_op("R9 sll 31",          5'd14, 32'h1,         32'd31,       16'h0, 32'h8000_0000, 1'b0);
      run_op("R9 srl 31",          5'd15, 32'h8000_0000, 32'd31,       16'h0, 32'h1, 1'b0);
      run_op("R9 sra negative",    5'd16, 32'h8000_0000, 32'd4,        16'h0, 32'hF800_0000, 1'b0);
      run_op("R9 sra positive",    5'd16, 32'h4000_0000, 32'd1,        16'h0, 32'h2000_0000, 1'b0);
      run_op("R9 amount masked",   5'd14, 32'h1,         32'hFFFF_FFE5, 16'h0, 32'h20, 1'b0);
      run_op("R9 srl zero amount", 5'd15, 32'h8765_4321, 32'h0000_0020, 16'h0, 32'h8765_4321, 1'b0);
   endtask

   task automatic t_cmp();
      run_op("R10 seq equal",  5'd17, 32'h1234_5678, 32'h1234_5678, 16'h0, 32'd1, 1'b0);
      run_op("R10 seq differ", 5'd17, 32'h1234_5678, 32'h1234_5679, 16'h0, 32'd0, 1'b0);
      run_op("R10 sne differ", 5'd18, 32'h0,         32'h8000_0000, 16'h0, 32'd1, 1'b0);
      run_op("R10 sne equal",  5'd18, 32'hCAFE_F00D, 32'hCAFE_F00D, 16'h0, 32'd0, 1'b0);
   endtask

   task automatic t_load();
      run_op("R11 byte signed",     5'd19, 32'h1234_5680, 32'h0, 16'h0, 32'hFFFF_FF80, 1'b0);
      run_op("R11 byte unsigned",   5'd20, 32'h1234_5680, 32'h0, 16'h0, 32'h0000_0080, 1'b0);
      run_op("R11 byte signed pos", 5'd19, 32'hFFFF_FF7F, 32'h0, 16'h0, 32'h0000_007F, 1'b0);
      run_op("R11 half signed",     5'd21, 32'h0000_8001, 32'h0, 16'h0, 32'hFFFF_8001, 1'b0);
      run_op("R11 half unsigned",   5'd22, 32'hFFFF_8001, 32'h0, 16'h0, 32'h0000_8001, 1'b0);
   endtask

   task automatic t_unused();
      run_op("R12 code 23", 5'd23, 32'h7FFF_FFFF, 32'h1, 16'hFFFF, 32'h0, 1'b0);
      run_op("R12 code 31", 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0, 1'b0);
   endtask

   task automatic t_hold();
      run_op("R1 issue before idle", 5'd0, 32'd1, 32'd2, 16'h0, 32'd3, 1'b0);
      op = 5'd5; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R1 idle holds result", {out_valid, result, ovf, out_wr_en},
               {1'b0, 32'd3, 1'b0, 1'b0});
      end
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      in_valid = 1'b1; op = 5'd0; opnd_a = 32'd100; opnd_b = 32'd23; imm = 16'h0;
      @(negedge clk);
      check("R1 back-to-back first", {out_valid, result, ovf, out_wr_en},
            {1'b1, 32'd123, 1'b0, 1'b1});
      op = 5'd0; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'h7FFF_FFFF;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 R4 back-to-back overflow", {out_valid, result, ovf, out_wr_en},
            {1'b1, 32'hFFFF_FFFE, 1'b1, 1'b0});
      @(negedge clk);
      check("R1 valid drops", {out_valid, result, ovf, out_wr_en},
            {1'b0, 32'hFFFF_FFFE, 1'b1, 1'b0});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_addsub();
      t_logic();
      t_imm();
      t_lui();
      t_shift();
      t_cmp();
      t_load();
      t_unused();
      t_hold();
      t_back_to_back();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired before completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule